// File: doc/BRIEF.md
# Wake Event and Power-Management Event Controller

This block collects the wake sources of a network interface and turns them into two active-low outputs: a power-management event request toward the host bus and an ordinary host interrupt. It watches a wakeup pulse from the MAC, which covers both a matched wakeup frame and a magic packet, and an energy-detect interrupt from the PHY. Each source sets a sticky status bit. Software reads and clears these bits through a small synchronous register port.

The host's power-state field and PME-enable bit arrive as plain inputs. If the function enters D3 while PME is disabled, the block asks the PHY to power down and stops detecting wake events until the function leaves D3. In D0 every detected event is also recorded in an interrupt status register, and the host interrupt follows that register through its own enables.

Top module: `wake_pme_ctrl`

## Requirements
- R1: The register port uses a 2-bit address. Address 0 is the wake-enable register: bit 0 enables the MAC source and bit 1 enables the energy source. Address 2 is the interrupt-enable register, with the same bit order. A write takes effect at the clock edge where `reg_wr_en` is high. `reg_rdata` shows the register at `reg_addr` one clock later.
- R2: Each wake input passes through two flip-flops. A rising edge of the synchronized level sets the matching wake status bit (address 1, bit 0 MAC, bit 1 energy), whether or not that source is enabled. Writing 1 to a status bit clears it, and a set in the same cycle as the clear wins.
- R3: If a wake status bit is already set when its enable is written to 1, `pme_n_out` goes low on the clock after the write.
- R4: A write-one-to-clear of a wake status bit does nothing while the synchronized level of its source is still high.
- R5: `pme_n_out` is low exactly when PME enable is 1 and some wake status bit and its enable are both set. It stays low until the host clears the responsible bits.
- R6: In D0 (state 2'b00), a detected event also sets the same-numbered bit of the interrupt status register (address 3, write-one-to-clear). `irq_n_out` is low while any interrupt status bit and its interrupt enable are both set.
- R7: With PME enable at 0, `pme_n_out` stays high in every power state. Outside D0, `irq_n_out` stays high and no interrupt status bit is set.
- R8: Entering D3 (state 2'b11) with PME enable at 0 raises `phy_pwrdn_out` until the state leaves D3. During that time no wake status bit is set, and turning PME enable on does not re-arm detection.
- R9: Reset clears every status and enable bit and drives `pme_n_out` and `irq_n_out` high and `phy_pwrdn_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mac_wake_in | input | 1 | MAC wakeup indication (frame or magic packet), asynchronous |
| phy_energy_in | input | 1 | PHY energy-detect interrupt, asynchronous |
| pm_state_in | input | 2 | Host power state, 2'b00 = D0, 2'b11 = D3 |
| pme_en_in | input | 1 | Host PME enable |
| reg_addr | input | 2 | Register address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 2 | Register write data, one bit per source |
| reg_rdata | output | 2 | Registered read data |
| pme_n_out | output | 1 | Active-low power-management event |
| irq_n_out | output | 1 | Active-low host interrupt |
| phy_pwrdn_out | output | 1 | PHY reset/power-down request |

## Verification
The hardest state to reach is a status clear that arrives while the source is still high. The bench holds the MAC input high across a clear write and reads the bit back still set. It then drops the input and waits for the synchronizer to drain before it clears again. The power-down path needs D3 entry and PME disable in the same step, followed by a source edge and then a late PME enable. The readback must show no status and the power-down request must stay latched.

// File: rtl/wake_pme_pkg.sv
package wake_pme_pkg;
  localparam int ADDR_W  = 2;
  localparam int SRC_MAC = 0;
  localparam int SRC_PHY = 1;

  typedef enum logic [ADDR_W-1:0] {
    A_WAKE_EN  = 2'd0,
    A_WAKE_ST  = 2'd1,
    A_IRQ_EN   = 2'd2,
    A_IRQ_ST   = 2'd3
  } reg_sel_e;

  localparam logic [1:0] PS_D0 = 2'b00;
  localparam logic [1:0] PS_D3 = 2'b11;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int NUM_SRC = 2,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_in,
  output logic [NUM_SRC-1:0] lvl_out,
  output logic [NUM_SRC-1:0] rise_out
);
  localparam int LAST = STAGES - 1;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], src_in[s]};
        prev_q  <= chain_q[LAST];
      end
    end

    assign lvl_out[s]  = chain_q[LAST];
    assign rise_out[s] = chain_q[LAST] & ~prev_q;
  end
endmodule

// File: rtl/wake_regs.sv
module wake_regs
  import wake_pme_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] rise,
  input  logic [NUM_SRC-1:0] lvl,
  input  logic               detect_en,
  input  logic               in_d0,
  output logic [NUM_SRC-1:0] wake_en,
  output logic [NUM_SRC-1:0] wake_st,
  output logic [NUM_SRC-1:0] irq_en,
  output logic [NUM_SRC-1:0] irq_st,
  output logic [NUM_SRC-1:0] rdata
);
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] wst_clr;
  logic [NUM_SRC-1:0] ist_clr;
  logic [NUM_SRC-1:0] ist_set;
  logic               wr_wen, wr_wst, wr_ien, wr_ist;

  assign wr_wen = wr_en && (addr == A_WAKE_EN);
  assign wr_wst = wr_en && (addr == A_WAKE_ST);
  assign wr_ien = wr_en && (addr == A_IRQ_EN);
  assign wr_ist = wr_en && (addr == A_IRQ_ST);

  assign hit     = rise & {NUM_SRC{detect_en}};
  assign ist_set = hit & {NUM_SRC{in_d0}};
  assign wst_clr = wr_wst ? (wdata & ~lvl) : '0;
  assign ist_clr = wr_ist ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_en <= '0;
      irq_en  <= '0;
      wake_st <= '0;
      irq_st  <= '0;
    end else begin
      if (wr_wen) wake_en <= wdata;
      if (wr_ien) irq_en  <= wdata;
      wake_st <= (wake_st & ~wst_clr) | hit;
      irq_st  <= (irq_st & ~ist_clr) | ist_set;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      unique case (addr)
        A_WAKE_EN: rdata <= wake_en;
        A_WAKE_ST: rdata <= wake_st;
        A_IRQ_EN:  rdata <= irq_en;
        default:   rdata <= irq_st;
      endcase
    end
  end
endmodule

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import wake_pme_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         pm_state,
  input  logic               pme_en,
  input  logic [NUM_SRC-1:0] wake_en,
  input  logic [NUM_SRC-1:0] wake_st,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic [NUM_SRC-1:0] irq_st,
  output logic               pme_n,
  output logic               irq_n,
  output logic               pwrdn,
  output logic               detect_en,
  output logic               in_d0
);
  logic in_d3;
  logic was_d3_q;

  assign in_d3     = (pm_state == PS_D3);
  assign in_d0     = (pm_state == PS_D0);
  assign detect_en = ~pwrdn;

  always_ff @(posedge clk) begin
    if (rst) begin
      was_d3_q <= 1'b0;
      pwrdn    <= 1'b0;
      pme_n    <= 1'b1;
      irq_n    <= 1'b1;
    end else begin
      was_d3_q <= in_d3;
      pwrdn    <= in_d3 && (pwrdn || (!was_d3_q && !pme_en));
      pme_n    <= ~(pme_en && |(wake_en & wake_st));
      irq_n    <= ~(in_d0 && |(irq_en & irq_st));
    end
  end
endmodule

// File: rtl/wake_pme_ctrl.sv
module wake_pme_ctrl
  import wake_pme_pkg::*;
#(
  parameter int NUM_SRC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mac_wake_in,
  input  logic               phy_energy_in,
  input  logic [1:0]         pm_state_in,
  input  logic               pme_en_in,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr_en,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               pme_n_out,
  output logic               irq_n_out,
  output logic               phy_pwrdn_out
);
  logic [NUM_SRC-1:0] src_raw;
  logic [NUM_SRC-1:0] src_lvl_w;
  logic [NUM_SRC-1:0] src_rise_w;
  logic [NUM_SRC-1:0] wake_en_w, wstat_w, irq_en_w, istat_w;
  logic               detect_en_w, in_d0_w;

  always_comb begin
    src_raw          = '0;
    src_raw[SRC_MAC] = mac_wake_in;
    src_raw[SRC_PHY] = phy_energy_in;
  end

  wake_sync #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .src_in(src_raw),
    .lvl_out(src_lvl_w), .rise_out(src_rise_w)
  );

  wake_regs #(.NUM_SRC(NUM_SRC)) regs_i (
    .clk(clk), .rst(rst), .addr(reg_addr), .wr_en(reg_wr_en),
    .wdata(reg_wdata), .rise(src_rise_w), .lvl(src_lvl_w),
    .detect_en(detect_en_w), .in_d0(in_d0_w),
    .wake_en(wake_en_w), .wake_st(wstat_w), .irq_en(irq_en_w),
    .irq_st(istat_w), .rdata(reg_rdata)
  );

  pm_ctrl #(.NUM_SRC(NUM_SRC)) pm_i (
    .clk(clk), .rst(rst), .pm_state(pm_state_in), .pme_en(pme_en_in),
    .wake_en(wake_en_w), .wake_st(wstat_w), .irq_en(irq_en_w),
    .irq_st(istat_w), .pme_n(pme_n_out), .irq_n(irq_n_out),
    .pwrdn(phy_pwrdn_out), .detect_en(detect_en_w), .in_d0(in_d0_w)
  );
endmodule

// File: rtl/wake_pme_ctrl_chk.sv
module wake_pme_ctrl_chk #(
  parameter int NUM_SRC = 2
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         pm_state_in,
  input logic               pme_en_in,
  input logic               pme_n_out,
  input logic               irq_n_out,
  input logic               phy_pwrdn_out,
  input logic [NUM_SRC-1:0] wstat,
  input logic [NUM_SRC-1:0] src_lvl
);
  AST_PME_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    !pme_n_out |-> $past(pme_en_in)); // R7

  AST_IRQ_ONLY_IN_D0: assert property (@(posedge clk) disable iff (rst)
    !irq_n_out |-> ($past(pm_state_in) == 2'b00)); // R7

  AST_PWRDN_ONLY_IN_D3: assert property (@(posedge clk) disable iff (rst)
    phy_pwrdn_out |-> ($past(pm_state_in) == 2'b11)); // R8

  AST_NO_WAKE_WHILE_PWRDN: assert property (@(posedge clk) disable iff (rst)
    $rose(wstat[0]) |-> !$past(phy_pwrdn_out)); // R8

  AST_MAC_CLEAR_HELD: assert property (@(posedge clk) disable iff (rst)
    (wstat[0] && src_lvl[0]) |=> wstat[0]); // R4

  AST_PHY_CLEAR_HELD: assert property (@(posedge clk) disable iff (rst)
    (wstat[1] && src_lvl[1]) |=> wstat[1]); // R4
endmodule

bind wake_pme_ctrl wake_pme_ctrl_chk #(.NUM_SRC(NUM_SRC)) chk_i (
  .clk(clk), .rst(rst), .pm_state_in(pm_state_in), .pme_en_in(pme_en_in),
  .pme_n_out(pme_n_out), .irq_n_out(irq_n_out),
  .phy_pwrdn_out(phy_pwrdn_out), .wstat(wstat_w), .src_lvl(src_lvl_w)
);

// File: tb/wake_pme_ctrl_tb_top.sv
`timescale 1ns/1ps
module wake_pme_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mac = 1'b0, phy = 1'b0, pme_en = 1'b0, wr = 1'b0;
  logic [1:0] st = 2'b00, addr = 2'b00, wd = 2'b00;
  logic [1:0] rdata;
  logic       pme_n, irq_n, pwrdn;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  wake_pme_ctrl dut_i (
    .clk(clk), .rst(rst), .mac_wake_in(mac), .phy_energy_in(phy),
    .pm_state_in(st), .pme_en_in(pme_en), .reg_addr(addr),
    .reg_wr_en(wr), .reg_wdata(wd), .reg_rdata(rdata),
    .pme_n_out(pme_n), .irq_n_out(irq_n), .phy_pwrdn_out(pwrdn)
  );

  // {mac,phy,state[1:0],pme_en,wr,addr[1:0],wdata[1:0] | pme_n,irq_n,pwrdn,wstat[1:0]}
  localparam logic [14:0] VEC [24] = '{
    15'b0_0_00_1_1_00_11_1_1_0_00, // R1 enable both sources
    15'b1_0_00_1_1_10_01_0_0_0_01, // R2 R5 R6 MAC edge
    15'b1_0_00_1_1_01_01_0_0_0_01, // R4 clear while high
    15'b0_0_00_1_0_00_00_0_0_0_01, // R5 stays low
    15'b0_0_00_1_1_01_01_1_0_0_00, // R2 R5 clear
    15'b0_0_00_1_1_11_01_1_1_0_00, // R6 clear irq status
    15'b0_1_00_1_0_00_00_0_1_0_10, // R2 energy edge
    15'b0_0_00_1_0_00_00_0_1_0_10, // R5
    15'b0_0_00_1_1_01_10_1_1_0_00, // R2 clear energy
    15'b1_0_00_1_1_00_00_1_0_0_01, // R2 set with enable off
    15'b0_0_00_1_1_11_11_1_1_0_01, // R6
    15'b0_0_00_1_1_00_01_0_1_0_01, // R3 enable on set bit
    15'b0_0_00_1_1_01_01_1_1_0_00, // R5
    15'b1_0_11_1_0_00_00_0_1_0_01, // R7 D3 armed, no irq
    15'b0_0_11_1_0_00_00_0_1_0_01, // R5
    15'b0_0_11_1_1_01_01_1_1_0_00, // R5
    15'b0_0_00_0_0_00_00_1_1_0_00, // R9-like idle
    15'b1_0_11_0_0_00_00_1_1_1_00, // R8 D3 without PME
    15'b0_0_11_1_0_00_00_1_1_1_00, // R8 late enable
    15'b0_0_00_1_0_00_00_1_1_0_00, // R8 leave D3
    15'b1_0_00_0_0_00_00_1_0_0_01, // R7 PME off
    15'b1_0_00_1_0_00_00_0_0_0_01, // R5
    15'b1_0_01_1_0_00_00_0_1_0_01, // R7 not D0
    15'b1_0_00_1_0_00_00_0_0_0_01  // R6
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [1:0] d);
    @(negedge clk); wr = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    d = rdata;
  endtask

  task automatic apply(input logic [14:0] v);
    logic [1:0] ws;
    @(negedge clk);
    mac = v[14]; phy = v[13]; st = v[12:11]; pme_en = v[10];
    wr = v[9]; addr = v[8:7]; wd = v[6:5];
    @(posedge clk); @(negedge clk); wr = 1'b0;
    repeat (4) @(posedge clk);
    read_reg(2'd1, ws);
    check("R5 pme_n", {3'b0, pme_n}, {3'b0, v[4]});
    check("R6 irq_n", {3'b0, irq_n}, {3'b0, v[3]});
    check("R8 pwrdn", {3'b0, pwrdn}, {3'b0, v[2]});
    check("R2 wstat", {2'b0, ws}, {2'b0, v[1:0]});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [1:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R9 reset state
    check("R9 outputs", {1'b0, pme_n, irq_n, pwrdn}, 4'b0110);
    read_reg(2'd0, d);
    check("R9 wake enables", {2'b0, d}, 4'b0000);

    for (int i = 0; i < 24; i++) apply(VEC[i]);

    // R1 readback of enable registers
    read_reg(2'd0, d);
    check("R1 wake enable readback", {2'b0, d}, 4'b0001);
    read_reg(2'd2, d);
    check("R1 irq enable readback", {2'b0, d}, 4'b0001);
    read_reg(2'd3, d);
    check("R6 irq status readback", {2'b0, d}, 4'b0001);

    // R9 reset clears sticky status and outputs
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0; mac = 1'b0;
    check("R9 outputs after reset", {1'b0, pme_n, irq_n, pwrdn}, 4'b0110);
    read_reg(2'd1, d);
    check("R9 wake status cleared", {2'b0, d}, 4'b0000);
    read_reg(2'd3, d);
    check("R9 irq status cleared", {2'b0, d}, 4'b0000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule